// File: doc/BRIEF.md
# Field Delay Memory Read Port Controller

This block is the read side of a serial field-delay memory. It runs on its own read clock, independent of the write side, and holds the read pointer that addresses the storage array. Each clock in which the read-advance input is high, the word at the current pointer is captured into an output register and the pointer moves on by one. When that input is low, the pointer and the captured word both hold. A separate drive-enable input does not affect the pointer. It only decides whether the captured word appears on the output bus. This lets a consumer skip words by clocking through them with the output blanked.

A restart input sets the pointer to a start address. While the restart input is high, one start-address bit per clock is taken from a serial pin, least significant bit first. The pointer follows the partially assembled address, so when restart drops the pointer already holds the full start address. The storage array sits outside the block. It receives the pointer on `mem_addr` and returns the addressed word on `mem_rdata` in the same cycle. The output register adds the single cycle of latency.

The output side is a paced stream with no back-pressure: there is no ready input. The consumer sets the pace with `rd_adv`, and `dout_drv` plays the role of the valid flag, telling the consumer whether `dout` carries a word this cycle. A consumer that cannot take a word holds `rd_adv` low. The pointer then stays put and no word is lost.

Top module: `fld_rd_port`

## Requirements
- R1: On a rising clock edge with `rd_restart` low and `rd_adv` high, the pointer on `mem_addr` increases by one. A pointer equal to or above DEPTH-1 goes to 0 instead.
- R2: On a rising clock edge with `rd_restart` low and `rd_adv` low, `mem_addr` keeps its value.
- R3: On an edge where the pointer advances, the output register captures `mem_rdata` as it stood before that edge, which is the word at the old pointer. The register holds that word through every edge that does not advance.
- R4: `dout_drv` takes the value that `drv_en` had at the previous rising edge. The pointer advances per R1 whatever the value of `drv_en`.
- R5: Whenever `dout_drv` is low, `dout` is all zeros. When `dout_drv` is high, `dout` shows the captured word with the same bit polarity as `mem_rdata`.
- R6: While `rd_restart` is high, the k-th consecutive restart edge (k = 0, 1, ...) places `addr_bit` into bit k of the start address, least significant bit first. After each such edge `mem_addr` equals the address assembled so far, with every bit not yet received at zero.
- R7: Serial bits after the first AW in one restart pulse are ignored. Each new restart pulse begins again at bit 0, with the start address cleared.
- R8: `rd_restart` overrides `rd_adv`. During restart the pointer never increments and the output register never captures a word.
- R9: While `rst_n` is low, `mem_addr`, `dout` and `dout_drv` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_restart | input | 1 | Restart; while high, start-address bits are shifted in |
| addr_bit | input | 1 | Serial start-address bit, LSB first |
| rd_adv | input | 1 | Read advance; high moves the pointer and captures a word |
| drv_en | input | 1 | Output drive request for the next cycle |
| mem_addr | output | AW | Read pointer to the storage array |
| mem_rdata | input | DW | Word returned by the array for `mem_addr` |
| dout | output | DW | Output data; zero when not driven |
| dout_drv | output | 1 | Output drive enable (valid flag of the stream) |

## Verification
The hardest conditions to reach from the ports are a start address at or above the wrap limit and a serial load longer or shorter than AW bits. Both depend on exact restart pulse lengths and bit patterns. The bench uses a 5-bit pointer with a depth of 24. It loads every one of the 32 possible start addresses, so the 8 out-of-range values are covered. After each load it advances with changing drive patterns, so over-range wrap, skipping and holding all appear. Separate pulses of 7 and 3 bits exercise ignored surplus bits and zero-filled upper bits.

// File: rtl/fld_rd_pkg.sv
package fld_rd_pkg;
  localparam int unsigned DEF_AW    = 21;
  localparam int unsigned DEF_DW    = 24;
  localparam int unsigned DEF_DEPTH = 1114112;
endpackage

// File: rtl/fld_rd_addr_loader.sv
module fld_rd_addr_loader #(
  parameter int unsigned AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          bit_in,
  output logic [AW-1:0] next_addr
);
  localparam int unsigned CW = $clog2(AW + 1);
  localparam logic [CW-1:0] FULL = CW'(AW);

  logic [AW-1:0] acc_q;
  logic [CW-1:0] cnt_q;

  // Bit i takes the serial input only on the edge whose count equals i.
  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign next_addr[i] = (cnt_q == CW'(i)) ? bit_in : acc_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (!load) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= next_addr;
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fld_rd_pointer.sv
module fld_rd_pointer #(
  parameter int unsigned AW    = 21,
  parameter int unsigned DEPTH = 1114112
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (load)     ptr <= load_addr;
    else if (adv)      ptr <= (ptr >= LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/fld_rd_out_stage.sv
module fld_rd_out_stage #(
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] word_in,
  input  logic          drv_req,
  output logic [DW-1:0] dout,
  output logic          drv
);
  logic [DW-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      drv    <= 1'b0;
    end else begin
      if (capture) word_q <= word_in;
      drv <= drv_req;
    end
  end

  assign dout = drv ? word_q : '0;
endmodule

// File: rtl/fld_rd_port.sv
module fld_rd_port
  import fld_rd_pkg::*;
#(
  parameter int unsigned AW    = DEF_AW,
  parameter int unsigned DW    = DEF_DW,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_restart,
  input  logic          addr_bit,
  input  logic          rd_adv,
  input  logic          drv_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] dout,
  output logic          dout_drv
);
  logic [AW-1:0] start_addr;
  logic          step;

  // Restart wins over advance.
  assign step = rd_adv & ~rd_restart;

  fld_rd_addr_loader #(.AW(AW)) u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_restart),
    .bit_in    (addr_bit),
    .next_addr (start_addr)
  );

  fld_rd_pointer #(.AW(AW), .DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_restart),
    .load_addr (start_addr),
    .adv       (step),
    .ptr       (mem_addr)
  );

  fld_rd_out_stage #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (step),
    .word_in (mem_rdata),
    .drv_req (drv_en),
    .dout    (dout),
    .drv     (dout_drv)
  );
endmodule

// File: rtl/fld_rd_port_chk.sv
module fld_rd_port_chk #(
  parameter int unsigned AW    = 21,
  parameter int unsigned DW    = 24,
  parameter int unsigned DEPTH = 1114112
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_restart,
  input logic          rd_adv,
  input logic          drv_en,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] dout,
  input logic          dout_drv
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  p_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_restart && rd_adv) |=>
      mem_addr == (($past(mem_addr) >= LAST) ? '0 : $past(mem_addr) + 1'b1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_restart && !rd_adv) |=> $stable(mem_addr));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_restart && rd_adv && drv_en) |=> dout == $past(mem_rdata));

  p_drv_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |=> dout_drv);

  p_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |=> (!dout_drv && dout == '0));

  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_restart && drv_en && dout_drv) |=> $stable(dout));

  p_nostep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_adv && drv_en && dout_drv) |=> $stable(dout));

  always_comb begin
    if (!rst_n) begin
      a_reset_r9: assert (mem_addr == '0 && dout == '0 && !dout_drv);
    end
  end
endmodule

bind fld_rd_port fld_rd_port_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_restart (rd_restart),
  .rd_adv     (rd_adv),
  .drv_en     (drv_en),
  .mem_addr   (mem_addr),
  .mem_rdata  (mem_rdata),
  .dout       (dout),
  .dout_drv   (dout_drv)
);

// File: tb/fld_rd_port_tb.sv
module fld_rd_port_tb;
  localparam int AW    = 5;
  localparam int DW    = 8;
  localparam int DEPTH = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_restart = 1'b0;
  logic          addr_bit = 1'b0;
  logic          rd_adv = 1'b0;
  logic          drv_en = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] dout;
  logic          dout_drv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int e_ptr = 0;
  int e_word = 0;
  int e_drv = 0;
  int e_acc = 0;
  int e_cnt = 0;

  always #10 clk = ~clk;

  // Array model: combinational read of a computed pattern.
  function automatic int pat(input int a);
    return (a * 37 + 5) % 256;
  endfunction
  assign mem_rdata = DW'(pat(int'(mem_addr)));

  fld_rd_port #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_restart (rd_restart),
    .addr_bit   (addr_bit),
    .rd_adv     (rd_adv),
    .drv_en     (drv_en),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .dout       (dout),
    .dout_drv   (dout_drv)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit b, input bit en, input bit oe, input string tag);
    rd_restart = r; addr_bit = b; rd_adv = en; drv_en = oe;
    @(posedge clk);
    if (r) begin
      if (e_cnt < AW) begin
        if (b) e_acc = e_acc | (1 << e_cnt);
        e_cnt++;
      end
      e_ptr = e_acc;
    end else begin
      e_acc = 0; e_cnt = 0;
      if (en) begin
        e_word = pat(e_ptr);
        e_ptr = (e_ptr >= DEPTH - 1) ? 0 : e_ptr + 1;
      end
    end
    e_drv = oe;
    @(negedge clk);
    chk(int'(mem_addr) == e_ptr, {tag, " addr"}, int'(mem_addr), e_ptr);
    chk(int'(dout_drv) == e_drv, {tag, " drv"}, int'(dout_drv), e_drv);
    chk(int'(dout) == (e_drv ? e_word : 0), {tag, " data"}, int'(dout), e_drv ? e_word : 0);
  endtask

  task automatic load(input int a, input int nbits, input string tag);
    for (int k = 0; k < nbits; k++) step(1'b1, a[k], 1'b1, 1'b1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_addr == '0, "R9 addr", int'(mem_addr), 0);
    chk(dout == '0, "R9 data", int'(dout), 0);
    chk(!dout_drv, "R9 drv", int'(dout_drv), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Every start address, including those past the wrap limit (R1, R6, R8).
    for (int a = 0; a < (1 << AW); a++) begin
      load(a, AW, "R6 load");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R1 R3 adv");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R2 hold");
      step(1'b0, 1'b0, 1'b1, a[0], "R4 R5 skip");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R1 wrap");
    end

    // Full lap with a drive pattern (R1, R4, R5).
    for (int k = 0; k < DEPTH + 3; k++)
      step(1'b0, 1'b0, k % 3 != 0, k % 2 == 0, "R1 R4 lap");

    // Surplus serial bits ignored (R7).
    load(32'h5A, 7, "R7 long");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R7 long end");
    // Short load leaves upper bits zero after a fresh pulse (R7).
    load(32'h5, 3, "R7 short");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R7 short adv");
    // Restart with advance low also loads (R8).
    for (int k = 0; k < AW; k++) step(1'b1, k == 1, 1'b0, 1'b0, "R8 noadv");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R3 after");
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule